// File: doc/BRIEF.md
# Stereo DAC Gain and Output-Disconnect Control

This block sits in front of the modulators of a two-channel audio DAC. Register writes arrive on a parallel port as 9-bit words. Each of the two gain registers takes a new 8-bit code only when the top bit of the same word is set. A mode register holds the soft-mute flag, the de-emphasis rate select, and the two bits that control how each channel's modulator is cut off from the output amplifier.

Each valid stereo frame is multiplied per channel by its gain factor and shifted right, and the result appears one clock later. Code 255 is treated as an exact multiplier of one. On the same strobe the block decides whether the output amplifiers are disconnected and held at mid-supply. A forced-ground bit disconnects on every frame. The zero-detect bit disconnects only on frames where both samples are zero.

Top module: `stereo_atten_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, out_valid, out_disc, out_mute and deemph_sel are all 0, and both gain codes are 255 (unity).
- R2: A write with wr_sel=00 (left) or wr_sel=01 (right) and wr_data[8]=1 loads wr_data[7:0] as that channel's gain code only. The new code applies to frames accepted from the next cycle on.
- R3: A gain write with wr_data[8]=0 leaves both gain codes unchanged.
- R4: For codes 0 to 254, each output sample is floor(sample*code/256), computed as a signed product followed by an arithmetic right shift of 8.
- R5: With code 255 the output sample equals the input sample exactly, including the values -32768 and 32767.
- R6: out_valid is in_valid delayed by one cycle. The samples and the disconnect flag of a frame appear in the cycle after in_valid was high.
- R7: When mode bit 3 (forced ground) is 1, out_disc is 1 for every frame, whatever the data.
- R8: When mode bit 3 is 0 and mode bit 4 (zero detect) is 1, out_disc is 1 only for frames where both samples are zero.
- R9: When mode bit 3 is 0 and either sample is non-zero, out_disc is 0. When both mode bits 3 and 4 are 0, a zero frame gives out_disc=0 and zero output samples.
- R10: out_disc, out_left and out_right change only on a frame strobe. A mode or gain write with no frame leaves them as they are.
- R11: A write with wr_sel=10 sets the mode register. out_mute is bit 0. deemph_sel is bits 2:1, encoded 00 off, 01 48 kHz, 10 44.1 kHz, 11 32 kHz. Both outputs follow in the cycle after the write.
- R12: Mode bits 8:5 are ignored. A write with wr_sel=11 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 00 left gain, 01 right gain, 10 mode, 11 none |
| wr_data | input | 9 | Write word |
| in_valid | input | 1 | Frame strobe |
| in_left | input | 16 | Left signed sample |
| in_right | input | 16 | Right signed sample |
| out_valid | output | 1 | Scaled frame valid |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |
| out_disc | output | 1 | Modulators disconnected, output held at mid-supply |
| out_mute | output | 1 | Soft-mute request |
| deemph_sel | output | 2 | De-emphasis rate select |

## Verification
The bench builds the block with its defaults: 16-bit samples and 8-bit gain codes. With 8-bit codes every code from 0 to 254 can be swept exhaustively, and the unity code 255 can be tested at both extremes of the sample range. The 16-bit width makes full-scale negative and positive samples reachable, where shift rounding and overflow would show. A seeded random mix of writes, with and without the latch bit, and frames with forced zeros then covers every combination of the two disconnect bits.

// File: rtl/stdac_pkg.sv
package stdac_pkg;

  typedef enum logic [1:0] {
    SEL_GAIN_L = 2'b00,
    SEL_GAIN_R = 2'b01,
    SEL_MODE   = 2'b10,
    SEL_NONE   = 2'b11
  } wr_target_e;

  typedef struct packed {
    logic       zdet;
    logic       fgnd;
    logic [1:0] demph;
    logic       mute;
  } mode_t;

  localparam int MODE_W = 5;

endpackage

// File: rtl/stdac_ctrl_regs.sv
module stdac_ctrl_regs
  import stdac_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_q_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW:0]   wr_data,
  output logic [CW-1:0] code_l,
  output logic [CW-1:0] code_r,
  output mode_t         mode
);

  localparam logic [CW-1:0] UNITY_CODE = {CW{1'b1}};

  logic [CW-1:0] code_l_d, code_r_d;
  mode_t         mode_d;
  logic          latch_bit;

  assign latch_bit = wr_data[CW];

  always_comb begin
    code_l_d = code_l;
    code_r_d = code_r;
    mode_d   = mode;
    if (wr_en) begin
      unique case (wr_target_e'(wr_sel))
        SEL_GAIN_L: if (latch_bit) code_l_d = wr_data[CW-1:0];
        SEL_GAIN_R: if (latch_bit) code_r_d = wr_data[CW-1:0];
        SEL_MODE:   mode_d = mode_t'(wr_data[MODE_W-1:0]);
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      code_l <= UNITY_CODE;
      code_r <= UNITY_CODE;
      mode   <= '0;
    end else begin
      code_l <= code_l_d;
      code_r <= code_r_d;
      mode   <= mode_d;
    end
  end

endmodule

// File: rtl/stdac_scale.sv
module stdac_scale #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_q_n,
  input  logic                 en,
  input  logic signed [DW-1:0] smp,
  input  logic [CW-1:0]        code,
  output logic signed [DW-1:0] smp_out
);

  localparam int            FW         = CW + 1;
  localparam int            PW         = DW + FW + 1;
  localparam logic [CW-1:0] UNITY_CODE = {CW{1'b1}};
  localparam logic [FW-1:0] UNITY_FAC  = FW'(1) << CW;

  logic [FW-1:0]        factor;
  logic signed [PW-1:0] prod;
  logic signed [DW-1:0] smp_d;
  logic                 unused_bits;

  always_comb begin
    factor = (code == UNITY_CODE) ? UNITY_FAC : {1'b0, code};
    prod   = PW'(smp) * $signed({1'b0, factor});
    smp_d  = prod[CW +: DW];
  end

  assign unused_bits = ^{prod[CW-1:0], prod[PW-1:CW+DW]};

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)  smp_out <= '0;
    else if (en)   smp_out <= smp_d;
  end

endmodule

// File: rtl/stdac_zero_gate.sv
module stdac_zero_gate #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_q_n,
  input  logic          en,
  input  logic          fgnd,
  input  logic          zdet,
  input  logic [DW-1:0] smp_l,
  input  logic [DW-1:0] smp_r,
  output logic          disc
);

  logic frame_zero;
  logic disc_d;

  always_comb begin
    frame_zero = (smp_l == '0) && (smp_r == '0);
    disc_d     = fgnd || (zdet && frame_zero);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) disc <= 1'b0;
    else if (en)  disc <= disc_d;
  end

endmodule

// File: rtl/stereo_atten_ctrl.sv
module stereo_atten_ctrl
  import stdac_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW:0]   wr_data,
  input  logic          in_valid,
  input  logic [DW-1:0] in_left,
  input  logic [DW-1:0] in_right,
  output logic          out_valid,
  output logic [DW-1:0] out_left,
  output logic [DW-1:0] out_right,
  output logic          out_disc,
  output logic          out_mute,
  output logic [1:0]    deemph_sel
);

  localparam int NCH = 2;

  logic [1:0]    rst_pipe;
  logic          rst_q_n;
  logic [CW-1:0] code_l, code_r;
  mode_t         mode;
  logic [DW-1:0] ch_in   [NCH];
  logic [CW-1:0] ch_code [NCH];
  logic [DW-1:0] ch_out  [NCH];
  logic          valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  stdac_ctrl_regs #(.CW(CW)) u_regs (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .code_l  (code_l),
    .code_r  (code_r),
    .mode    (mode)
  );

  assign ch_in[0]   = in_left;
  assign ch_in[1]   = in_right;
  assign ch_code[0] = code_l;
  assign ch_code[1] = code_r;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    stdac_scale #(.DW(DW), .CW(CW)) u_scale (
      .clk     (clk),
      .rst_q_n (rst_q_n),
      .en      (in_valid),
      .smp     (ch_in[c]),
      .code    (ch_code[c]),
      .smp_out (ch_out[c])
    );
  end

  stdac_zero_gate #(.DW(DW)) u_gate (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .en      (in_valid),
    .fgnd    (mode.fgnd),
    .zdet    (mode.zdet),
    .smp_l   (in_left),
    .smp_r   (in_right),
    .disc    (out_disc)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) valid_q <= 1'b0;
    else          valid_q <= in_valid;
  end

  assign out_valid  = valid_q;
  assign out_left   = ch_out[0];
  assign out_right  = ch_out[1];
  assign out_mute   = mode.mute;
  assign deemph_sel = mode.demph;

endmodule

// File: rtl/stereo_atten_ctrl_chk.sv
module stereo_atten_ctrl_chk #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [CW:0]   wr_data,
  input logic          in_valid,
  input logic [DW-1:0] in_left,
  input logic [DW-1:0] in_right,
  input logic          out_valid,
  input logic [DW-1:0] out_left,
  input logic [DW-1:0] out_right,
  input logic          out_disc,
  input logic [CW-1:0] code_l,
  input logic [CW-1:0] code_r,
  input logic [4:0]    mode_bits
);

  localparam logic [CW-1:0] UNITY_CODE = {CW{1'b1}};

  assert_valid_on_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);
  assert_valid_off_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> ($stable(out_disc) && $stable(out_left) && $stable(out_right)));
  assert_forced_gnd_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && mode_bits[3]) |=> out_disc);
  assert_nonzero_connect_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !mode_bits[3] && (in_left != '0 || in_right != '0)) |=> !out_disc);
  assert_unity_left_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && code_l == UNITY_CODE) |=> (out_left == $past(in_left)));
  assert_unity_right_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && code_r == UNITY_CODE) |=> (out_right == $past(in_right)));
  assert_no_latch_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_sel != 2'b10 && !wr_data[CW]) |=> ($stable(code_l) && $stable(code_r)));
  assert_sel_none_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_sel == 2'b11) |=> ($stable(mode_bits) && $stable(code_l) && $stable(code_r)));

endmodule

bind stereo_atten_ctrl stereo_atten_ctrl_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .in_valid  (in_valid),
  .in_left   (in_left),
  .in_right  (in_right),
  .out_valid (out_valid),
  .out_left  (out_left),
  .out_right (out_right),
  .out_disc  (out_disc),
  .code_l    (code_l),
  .code_r    (code_r),
  .mode_bits (mode)
);

// File: tb/stereo_atten_ctrl_tb.sv
`timescale 1ns/1ps
module stereo_atten_ctrl_tb;

  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [CW:0]   wr_data = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_left = '0;
  logic [DW-1:0] in_right = '0;
  logic          out_valid, out_disc, out_mute;
  logic [DW-1:0] out_left, out_right;
  logic [1:0]    deemph_sel;

  int checks = 0;
  int errors = 0;

  int       m_code_l = 255;
  int       m_code_r = 255;
  bit [4:0] m_mode = '0;

  always #2.5 clk = ~clk;

  stereo_atten_ctrl #(.DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .out_disc(out_disc), .out_mute(out_mute), .deemph_sel(deemph_sel)
  );

  function automatic longint exp_scale(logic [DW-1:0] s, int code);
    longint fac  = (code == 255) ? 256 : code;
    longint prod = longint'($signed(s)) * fac;
    return prod >>> 8;
  endfunction

  function automatic bit exp_disc(logic [DW-1:0] l, logic [DW-1:0] r);
    return m_mode[3] || (m_mode[4] && l == 0 && r == 0);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(logic [1:0] sel, logic [CW:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel == 2'b00 && data[CW]) m_code_l = int'(data[CW-1:0]);
    if (sel == 2'b01 && data[CW]) m_code_r = int'(data[CW-1:0]);
    if (sel == 2'b10) m_mode = data[4:0];
    check("R11 mute", longint'(out_mute), longint'(m_mode[0]));
    check("R11 deemph", longint'(deemph_sel), longint'(m_mode[2:1]));
  endtask

  task automatic send(logic [DW-1:0] l, logic [DW-1:0] r, string req);
    longint el = exp_scale(l, m_code_l);
    longint er = exp_scale(r, m_code_r);
    bit     ed = exp_disc(l, r);
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R6 valid"}, longint'(out_valid), 1);
    check({req, " left"}, longint'($signed(out_left)), el);
    check({req, " right"}, longint'($signed(out_right)), er);
    check({req, " disc"}, longint'(out_disc), longint'(ed));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] l, r;
    logic [DW-1:0] hold_l;
    void'($urandom(32'h5EED_0007));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", longint'(out_valid), 0);
    check("R1 disc in reset", longint'(out_disc), 0);
    check("R1 mute in reset", longint'(out_mute), 0);
    check("R1 deemph in reset", longint'(deemph_sel), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid after reset", longint'(out_valid), 0);

    // R1 R5: unity gain after reset, full-scale extremes
    send(16'h8000, 16'h7FFF, "R1 R5 unity");
    send(16'h7FFF, 16'h8000, "R5 unity");
    @(negedge clk);
    check("R6 valid drop", longint'(out_valid), 0);

    // R2: left only
    do_write(2'b00, 9'h180);
    send(16'hFFFF, 16'h1234, "R2 R4 left 128");
    // R3: no latch bit
    do_write(2'b01, 9'h010);
    do_write(2'b00, 9'h005);
    send(16'h4000, 16'hC000, "R3 unlatched");
    // R4 sweep all codes below unity
    for (int c = 0; c < 255; c++) begin
      do_write(2'b00, {1'b1, 8'(c)});
      do_write(2'b01, {1'b1, 8'(254 - c)});
      send(DW'($urandom), DW'($urandom), "R4 sweep");
    end
    // R9: both bits clear, zero frame
    do_write(2'b10, 9'h000);
    send(16'h0000, 16'h0000, "R9 zero pass");
    check("R9 zero out", longint'(out_left), 0);
    // R8 zero detect
    do_write(2'b10, 9'h010);
    send(16'h0000, 16'h0000, "R8 zero frame");
    send(16'h0000, 16'h0001, "R8 R9 right nonzero");
    send(16'hFFFF, 16'h0000, "R8 R9 left nonzero");
    // R7 forced ground
    do_write(2'b10, 9'h008);
    send(16'h1111, 16'h2222, "R7 forced");
    // R10: mode change without frame
    do_write(2'b10, 9'h000);
    send(16'h0101, 16'h0202, "R10 setup");
    hold_l = out_left;
    do_write(2'b10, 9'h008);
    do_write(2'b00, 9'h1FF);
    @(negedge clk);
    check("R10 disc held", longint'(out_disc), 0);
    check("R10 left held", longint'(out_left), longint'(hold_l));
    // R12 reserved bits and unused select
    do_write(2'b10, 9'h1E5);
    check("R12 reserved", longint'(deemph_sel), 2);
    do_write(2'b11, 9'h1FF);
    check("R12 sel none", longint'(deemph_sel), 2);
    send(16'h0003, 16'h0000, "R12 codes kept");
    // R11 each de-emphasis code
    for (int d = 0; d < 4; d++) do_write(2'b10, 9'(d << 1));

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        do_write(2'($urandom), 9'($urandom));
      end else begin
        l = ($urandom_range(0, 2) == 0) ? '0 : DW'($urandom);
        r = ($urandom_range(0, 2) == 0) ? '0 : DW'($urandom);
        send(l, r, "R4 R7 R8 random");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule